// File: doc/BRIEF.md
# Page-Mode External Read Sequencer

This block runs reads on an external parallel memory bus. It supports page-mode bursts, in which later reads into an already open page use a shorter access strobe. A host presents a 24-bit address with a valid/ready handshake. The sequencer turns each accepted address into bus activity: chip select, read enable, an address-latch strobe, dedicated address lines and a tri-state bus with per-byte-lane output enables. It returns the captured read data to the host with a one-cycle valid pulse.

Each read is built from up to four timed phases, each programmable in clock cycles. The phases are address setup, read setup, a strobe and read hold. The first read after the bus was idle uses the long strobe length. A following read uses the page strobe length when the host marks it as a page hit and offers it in the final strobe cycle of the read before it. Three bus layouts are supported:
- A 16-bit layout in which address and data share the bus.
- An 8-bit-data layout in which the upper address bytes are latched through both lanes and the low byte then stays on the lower lane.
- A 16-bit layout with separate address lines.

All phase lengths and the layout are sampled when a transaction starts from idle.

Top module: `pageReadSeq`

## Requirements
- R1: After reset csN=1, reN=1, ale=0, busOe=2'b00, rspValid=0 and reqReady=1.
- R2: A request accepted while idle runs address setup, read setup, strobe and hold in that order. csN is low from the cycle after acceptance until hold ends, and reN is low only in strobe cycles. rspValid pulses in the cycle after the last strobe cycle and carries the bus value sampled in that last cycle.
- R3: With cfgMode=0 (shared 16-bit), address setup lasts cfgAddrSetup cycles with 0 taken as 1. During it ale=1, busOut=addr[15:0] and busOe=2'b11. In every other cycle busOe=2'b00.
- R4: With cfgMode=1 (8-bit data), address setup lasts cfgAddrSetup cycles and may be 0, in which case ale never rises. During it ale=1, busOut={addr[23:16],addr[15:8]} and busOe=2'b11. Afterwards, while csN is low, busOut[7:0]=addr[7:0] with busOe=2'b01. rspData is {8'h00, busIn[15:8]}.
- R5: With cfgMode=2 (separate address), there is no address-setup phase and ale stays 0. busOe stays 2'b00, addrOut carries the address and rspData is busIn.
- R6: If reqValid and reqHit are high in the last strobe cycle, reqReady is high and the request is accepted there. In modes 1 and 2 the next beat runs only a page strobe of cfgPageStrobe cycles, with no hold or setup between the beats. csN stays low between beats.
- R7: In mode 0 an accepted page hit runs the hold of the current beat, then address setup, read setup and a page strobe, with csN held low throughout.
- R8: When no hit request is present in the last strobe cycle, the hold runs and csN returns high in the cycle after it. A later request starts again with the long strobe.
- R9: Strobe and page-strobe lengths of 0 act as 1. Read setup or hold of 0 removes that phase.
- R10: Configuration changes after a transaction has started have no effect on that transaction or its page beats.
- R11: While csN is low, reqReady is high only in a strobe cycle with reqHit high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgMode | input | 2 | Bus layout: 0 shared 16-bit, 1 8-bit data, 2 or 3 separate address |
| cfgAddrSetup | input | 4 | Address setup cycles |
| cfgRdSetup | input | 4 | Read setup cycles |
| cfgStrobe | input | 4 | First-beat strobe cycles |
| cfgPageStrobe | input | 4 | Page-hit strobe cycles |
| cfgHold | input | 4 | Read hold cycles |
| reqValid | input | 1 | Host request valid |
| reqReady | output | 1 | Request accepted this cycle when valid |
| reqAddr | input | 24 | Read address |
| reqHit | input | 1 | Request hits the open page |
| rspValid | output | 1 | One-cycle read data valid |
| rspData | output | 16 | Read data |
| csN | output | 1 | Chip select, active low |
| reN | output | 1 | Read enable, active low |
| ale | output | 1 | Address latch strobe |
| addrOut | output | 24 | Dedicated address lines |
| busOut | output | 16 | Shared bus drive value |
| busOe | output | 2 | Per-lane bus drive enable (bit 1 upper lane) |
| busIn | input | 16 | Shared bus sampled value |

## Verification
A read accepted from idle answers in the cycle that is effective address setup plus read setup plus effective strobe cycles after the accepting edge. A page beat in modes 1 and 2 answers after effective page-strobe cycles. In mode 0 a page beat answers after hold plus effective address setup plus read setup plus effective page-strobe cycles. The driver computes this due cycle from the configuration it applied at the start of the transaction and queues it with the expected data. The monitor compares the cycle of every rspValid with the queued value. The modelled memory answers only while reN is low, so a sample taken in any other cycle returns wrong data. The lane contents, chip-select timing and handshake gating are checked on falling edges, each cycle.

// File: rtl/pageReadPkg.sv
package pageReadPkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ASETUP,
    PH_RSETUP,
    PH_STRB,
    PH_PAGE,
    PH_HOLD
  } phaseE;

  typedef enum logic [1:0] {
    MODE_MUX16 = 2'd0,
    MODE_MUX8  = 2'd1,
    MODE_SEP16 = 2'd2,
    MODE_SEPX  = 2'd3
  } busModeE;

  // strobes from control to datapath
  typedef struct packed {
    logic    loadAddr;
    logic    capture;
    logic    aleOn;
    logic    readOn;
    logic    csOn;
    busModeE mode;
  } ctlStrobeT;

endpackage

// File: rtl/pageReadCtrl.sv
module pageReadCtrl
  import pageReadPkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       cfgMode,
  input  logic [CNT_W-1:0] cfgAddrSetup,
  input  logic [CNT_W-1:0] cfgRdSetup,
  input  logic [CNT_W-1:0] cfgStrobe,
  input  logic [CNT_W-1:0] cfgPageStrobe,
  input  logic [CNT_W-1:0] cfgHold,
  input  logic             reqValid,
  input  logic             reqHit,
  output logic             reqReady,
  output ctlStrobeT        ctl
);

  typedef struct packed {
    phaseE            ph;
    logic [CNT_W-1:0] cnt;
  } stepT;

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  function automatic logic [CNT_W-1:0] atLeastOne(input logic [CNT_W-1:0] v);
    return (v == '0) ? ONE : v;
  endfunction

  function automatic stepT strobeStep(input logic page, input logic [CNT_W-1:0] s,
                                      input logic [CNT_W-1:0] p);
    stepT t;
    if (page) begin
      t.ph  = PH_PAGE;
      t.cnt = p - ONE;
    end else begin
      t.ph  = PH_STRB;
      t.cnt = s - ONE;
    end
    return t;
  endfunction

  function automatic stepT afterAddr(input logic [CNT_W-1:0] r, input logic [CNT_W-1:0] s,
                                     input logic [CNT_W-1:0] p, input logic page);
    stepT t;
    if (r != '0) begin
      t.ph  = PH_RSETUP;
      t.cnt = r - ONE;
    end else begin
      t = strobeStep(page, s, p);
    end
    return t;
  endfunction

  function automatic stepT beatStep(input logic [CNT_W-1:0] a, input logic [CNT_W-1:0] r,
                                    input logic [CNT_W-1:0] s, input logic [CNT_W-1:0] p,
                                    input logic page);
    stepT t;
    if (a != '0) begin
      t.ph  = PH_ASETUP;
      t.cnt = a - ONE;
    end else begin
      t = afterAddr(r, s, p, page);
    end
    return t;
  endfunction

  phaseE            state;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lenA, lenR, lenS, lenP, lenH;
  busModeE          modeReg;
  logic             pageBeat, contBeat;

  // lengths as they would be captured at a transaction start
  busModeE          sMode;
  logic [CNT_W-1:0] sA, sS, sP;

  always_comb begin
    sMode = busModeE'(cfgMode);
    sS    = atLeastOne(cfgStrobe);
    sP    = atLeastOne(cfgPageStrobe);
    case (sMode)
      MODE_MUX16: sA = atLeastOne(cfgAddrSetup);
      MODE_MUX8:  sA = cfgAddrSetup;
      default:    sA = '0;
    endcase
  end

  logic lastCyc, inStrobe, strobeEnd, accept;

  always_comb begin
    lastCyc   = (cnt == '0);
    inStrobe  = (state == PH_STRB) || (state == PH_PAGE);
    strobeEnd = inStrobe && lastCyc;
    reqReady  = (state == PH_IDLE) || (strobeEnd && reqHit);
    accept    = reqValid && reqReady;
  end

  stepT nxt;
  logic nPage, nCont, loadLens;

  always_comb begin
    nxt.ph   = state;
    nxt.cnt  = lastCyc ? cnt : cnt - ONE;
    nPage    = pageBeat;
    nCont    = contBeat;
    loadLens = 1'b0;
    case (state)
      PH_IDLE: begin
        if (accept) begin
          nxt      = beatStep(sA, cfgRdSetup, sS, sP, 1'b0);
          nPage    = 1'b0;
          nCont    = 1'b0;
          loadLens = 1'b1;
        end
      end
      PH_ASETUP: begin
        if (lastCyc) nxt = afterAddr(lenR, lenS, lenP, pageBeat);
      end
      PH_RSETUP: begin
        if (lastCyc) nxt = strobeStep(pageBeat, lenS, lenP);
      end
      PH_STRB, PH_PAGE: begin
        if (lastCyc) begin
          if (accept) begin
            nPage = 1'b1;
            if (modeReg == MODE_MUX16) begin
              nCont = 1'b1;
              if (lenH != '0) begin
                nxt.ph  = PH_HOLD;
                nxt.cnt = lenH - ONE;
              end else begin
                nxt = beatStep(lenA, lenR, lenS, lenP, 1'b1);
              end
            end else begin
              nCont = 1'b0;
              nxt   = strobeStep(1'b1, lenS, lenP);
            end
          end else begin
            nCont = 1'b0;
            if (lenH != '0) begin
              nxt.ph  = PH_HOLD;
              nxt.cnt = lenH - ONE;
            end else begin
              nxt.ph  = PH_IDLE;
              nxt.cnt = '0;
            end
          end
        end
      end
      PH_HOLD: begin
        if (lastCyc) begin
          if (contBeat) begin
            nxt = beatStep(lenA, lenR, lenS, lenP, 1'b1);
          end else begin
            nxt.ph  = PH_IDLE;
            nxt.cnt = '0;
          end
        end
      end
      default: begin
        nxt.ph  = PH_IDLE;
        nxt.cnt = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= PH_IDLE;
      cnt      <= '0;
      lenA     <= '0;
      lenR     <= '0;
      lenS     <= ONE;
      lenP     <= ONE;
      lenH     <= '0;
      modeReg  <= MODE_MUX16;
      pageBeat <= 1'b0;
      contBeat <= 1'b0;
    end else begin
      state    <= nxt.ph;
      cnt      <= nxt.cnt;
      pageBeat <= nPage;
      contBeat <= nCont;
      if (loadLens) begin
        lenA    <= sA;
        lenR    <= cfgRdSetup;
        lenS    <= sS;
        lenP    <= sP;
        lenH    <= cfgHold;
        modeReg <= sMode;
      end
    end
  end

  always_comb begin
    ctl.loadAddr = accept;
    ctl.capture  = strobeEnd;
    ctl.aleOn    = (state == PH_ASETUP);
    ctl.readOn   = inStrobe;
    ctl.csOn     = (state != PH_IDLE);
    ctl.mode     = modeReg;
  end

endmodule

// File: rtl/pageReadDatapath.sv
module pageReadDatapath
  import pageReadPkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobeT         ctl,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] busIn,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData,
  output logic              csN,
  output logic              reN,
  output logic              ale,
  output logic [ADDR_W-1:0] addrOut,
  output logic [DATA_W-1:0] busOut,
  output logic [1:0]        busOe
);

  localparam int LANE_W = DATA_W / 2;

  logic [ADDR_W-1:0] addrReg;
  logic [DATA_W-1:0] sampled;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrReg  <= '0;
      sampled  <= '0;
      rspValid <= 1'b0;
    end else begin
      rspValid <= ctl.capture;
      if (ctl.loadAddr) addrReg <= reqAddr;
      if (ctl.capture) begin
        if (ctl.mode == MODE_MUX8) sampled <= {{LANE_W{1'b0}}, busIn[DATA_W-1 -: LANE_W]};
        else                       sampled <= busIn;
      end
    end
  end

  always_comb begin
    busOut = '0;
    busOe  = 2'b00;
    if (ctl.aleOn) begin
      case (ctl.mode)
        MODE_MUX16: begin
          busOut = addrReg[DATA_W-1:0];
          busOe  = 2'b11;
        end
        MODE_MUX8: begin
          busOut = {addrReg[3*LANE_W-1 -: LANE_W], addrReg[2*LANE_W-1 -: LANE_W]};
          busOe  = 2'b11;
        end
        default: busOe = 2'b00;
      endcase
    end else if (ctl.csOn && ctl.mode == MODE_MUX8) begin
      busOut[LANE_W-1:0] = addrReg[LANE_W-1:0];
      busOe              = 2'b01;
    end
  end

  assign rspData = sampled;
  assign csN     = ~ctl.csOn;
  assign reN     = ~ctl.readOn;
  assign ale     = ctl.aleOn;
  assign addrOut = addrReg;

endmodule

// File: rtl/pageReadSeq.sv
module pageReadSeq
  import pageReadPkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        cfgMode,
  input  logic [CNT_W-1:0]  cfgAddrSetup,
  input  logic [CNT_W-1:0]  cfgRdSetup,
  input  logic [CNT_W-1:0]  cfgStrobe,
  input  logic [CNT_W-1:0]  cfgPageStrobe,
  input  logic [CNT_W-1:0]  cfgHold,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqHit,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData,
  output logic              csN,
  output logic              reN,
  output logic              ale,
  output logic [ADDR_W-1:0] addrOut,
  output logic [DATA_W-1:0] busOut,
  output logic [1:0]        busOe,
  input  logic [DATA_W-1:0] busIn
);

  ctlStrobeT ctl;

  pageReadCtrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .cfgMode      (cfgMode),
    .cfgAddrSetup (cfgAddrSetup),
    .cfgRdSetup   (cfgRdSetup),
    .cfgStrobe    (cfgStrobe),
    .cfgPageStrobe(cfgPageStrobe),
    .cfgHold      (cfgHold),
    .reqValid     (reqValid),
    .reqHit       (reqHit),
    .reqReady     (reqReady),
    .ctl          (ctl)
  );

  pageReadDatapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .reqAddr (reqAddr),
    .busIn   (busIn),
    .rspValid(rspValid),
    .rspData (rspData),
    .csN     (csN),
    .reN     (reN),
    .ale     (ale),
    .addrOut (addrOut),
    .busOut  (busOut),
    .busOe   (busOe)
  );

endmodule

// File: rtl/pageReadChecker.sv
module pageReadChecker (
  input logic       clk,
  input logic       rstN,
  input logic       csN,
  input logic       reN,
  input logic       ale,
  input logic [1:0] busOe,
  input logic       rspValid,
  input logic       reqValid,
  input logic       reqReady
);

  // R2
  read_in_select_chk: assert property (@(posedge clk) disable iff (!rstN) !reN |-> !csN);

  // R2
  rsp_after_strobe_chk: assert property (@(posedge clk) disable iff (!rstN) rspValid |-> $past(!reN));

  // R3
  ale_drives_bus_chk: assert property (@(posedge clk) disable iff (!rstN) ale |-> busOe == 2'b11);

  // R3
  ale_not_with_read_chk: assert property (@(posedge clk) disable iff (!rstN) ale |-> reN);

  // R4
  upper_lane_released_chk: assert property (@(posedge clk) disable iff (!rstN) !reN |-> !busOe[1]);

  // R2
  idle_accept_selects_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && csN) |=> !csN);

endmodule

bind pageReadSeq pageReadChecker u_pageReadChecker (
  .clk     (clk),
  .rstN    (rstN),
  .csN     (csN),
  .reN     (reN),
  .ale     (ale),
  .busOe   (busOe),
  .rspValid(rspValid),
  .reqValid(reqValid),
  .reqReady(reqReady)
);

// File: tb/pageReadSeq_bench.sv
`timescale 1ns/100ps
module pageReadSeq_bench;

  logic        clk = 1'b0;
  logic        rstN;
  logic [1:0]  cfgMode;
  logic [3:0]  cfgAddrSetup, cfgRdSetup, cfgStrobe, cfgPageStrobe, cfgHold;
  logic        reqValid, reqReady, reqHit;
  logic [23:0] reqAddr;
  logic        rspValid;
  logic [15:0] rspData;
  logic        csN, reN, ale;
  logic [23:0] addrOut;
  logic [15:0] busOut;
  logic [1:0]  busOe;
  logic [15:0] busIn;

  always #2 clk = ~clk;

  pageReadSeq u_pageReadSeq (
    .clk(clk), .rstN(rstN), .cfgMode(cfgMode), .cfgAddrSetup(cfgAddrSetup),
    .cfgRdSetup(cfgRdSetup), .cfgStrobe(cfgStrobe), .cfgPageStrobe(cfgPageStrobe),
    .cfgHold(cfgHold), .reqValid(reqValid), .reqReady(reqReady), .reqAddr(reqAddr),
    .reqHit(reqHit), .rspValid(rspValid), .rspData(rspData), .csN(csN), .reN(reN),
    .ale(ale), .addrOut(addrOut), .busOut(busOut), .busOe(busOe), .busIn(busIn)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0;
  int fails  = 0;
  int expCycQ[$];
  logic [15:0] expDataQ[$];
  logic [23:0] curAddr = '0;
  int snapMode = 0, snapA = 0, snapR = 0, snapS = 1, snapP = 1, snapH = 0;
  int lastAcc = 0;

  function automatic logic [15:0] memF(input logic [23:0] a);
    return a[15:0] ^ {a[23:16], 8'h3C};
  endfunction

  // memory answers only while read enable is asserted
  assign busIn = !reN ? memF(addrOut) : 16'hBEEF;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic int effA(input int m, input int a);
    if (m == 0) return (a == 0) ? 1 : a;
    if (m == 1) return a;
    return 0;
  endfunction

  function automatic int atLeast1(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  task automatic issue(input logic [23:0] a, input bit hit);
    bit cont;
    int acc, lat, m, ea, er, es, ep, eh;
    @(negedge clk);
    #0.5;
    reqAddr  = a;
    reqHit   = hit;
    reqValid = 1'b1;
    #0.5;
    while (!reqReady) begin
      @(negedge clk);
      #1;
    end
    cont = !csN;
    acc  = cyc + 1;
    if (!cont) begin
      m  = int'(cfgMode);
      ea = effA(m, int'(cfgAddrSetup));
      er = int'(cfgRdSetup);
      es = atLeast1(int'(cfgStrobe));
      ep = atLeast1(int'(cfgPageStrobe));
      eh = int'(cfgHold);
      lat = ea + er + es;
    end else begin
      m = snapMode; ea = snapA; er = snapR; es = snapS; ep = snapP; eh = snapH;
      if (m == 0) lat = eh + ea + er + ep;
      else        lat = ep;
    end
    @(posedge clk);
    curAddr  = a;
    snapMode = m; snapA = ea; snapR = er; snapS = es; snapP = ep; snapH = eh;
    lastAcc  = acc;
    expCycQ.push_back(acc + lat);
    expDataQ.push_back((m == 1) ? {8'h00, memF(a)[15:8]} : memF(a));
    #1;
    reqValid = 1'b0;
    reqHit   = 1'b0;
  endtask

  task automatic setCfg(input int m, input int a, input int r, input int s, input int p, input int h);
    cfgMode       = 2'(m);
    cfgAddrSetup  = 4'(a);
    cfgRdSetup    = 4'(r);
    cfgStrobe     = 4'(s);
    cfgPageStrobe = 4'(p);
    cfgHold       = 4'(h);
  endtask

  task automatic drain();
    while (expCycQ.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic waitCyc(input int n);
    do @(negedge clk); while (cyc < n);
  endtask

  // monitor: responses against the scoreboard, bus lanes every cycle
  always @(negedge clk) begin
    if (rstN) begin
      if (rspValid) begin
        if (expCycQ.size() == 0) begin
          check(1'b0, "R2 unexpected response", int'(rspData), 0);
        end else begin
          int ec;
          logic [15:0] ed;
          ec = expCycQ.pop_front();
          ed = expDataQ.pop_front();
          check(cyc == ec, "R2 response cycle", cyc, ec);
          check(rspData == ed, "R2 response data", int'(rspData), int'(ed));
        end
      end
      if (expCycQ.size() != 0) check(!csN, "R6 R7 select held while read outstanding", int'(csN), 0);
      if (!csN && reqReady) check(!reN && reqHit, "R11 ready while busy", int'({reN, reqHit}), 1);
      if (ale) begin
        if (snapMode == 0)
          check(busOut == curAddr[15:0] && busOe == 2'b11, "R3 address phase", int'(busOut), int'(curAddr[15:0]));
        else if (snapMode == 1)
          check(snapA != 0 && busOe == 2'b11 && busOut == {curAddr[23:16], curAddr[15:8]},
                "R4 latch phase", int'(busOut), int'({curAddr[23:16], curAddr[15:8]}));
        else
          check(1'b0, "R5 latch strobe in separate mode", 1, 0);
      end else if (!csN && snapMode == 0) begin
        check(busOe == 2'b00, "R3 bus released", int'(busOe), 0);
      end
      if (!csN && snapMode == 1 && !ale)
        check(busOe == 2'b01 && busOut[7:0] == curAddr[7:0], "R4 low lane address", int'(busOut[7:0]), int'(curAddr[7:0]));
      if (snapMode >= 2) begin
        check(busOe == 2'b00, "R5 bus never driven", int'(busOe), 0);
        if (!csN) check(addrOut == curAddr, "R5 address lines", int'(addrOut), int'(curAddr));
      end
    end
  end

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    wait (cyc >= 150000);
    check(1'b0, "watchdog expired", cyc, 150000);
    finishRun();
  end

  initial begin
    rstN = 1'b0;
    reqValid = 1'b0; reqHit = 1'b0; reqAddr = '0;
    setCfg(0, 2, 1, 3, 2, 1);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1
    check(csN && reN && !ale && busOe == 2'b00 && !rspValid && reqReady, "R1 reset state",
          int'({csN, reN, ale, busOe, rspValid, reqReady}), 7'b1100001);

    // R2 R8: isolated shared-bus read, select released after one hold cycle
    issue(24'h001234, 1'b0);
    waitCyc(lastAcc + 6);
    check(!csN, "R8 select low in hold", int'(csN), 0);
    waitCyc(lastAcc + 7);
    check(csN, "R8 select high after hold", int'(csN), 1);
    drain();

    // R7: shared-bus page burst
    issue(24'h00A100, 1'b0);
    issue(24'h00A101, 1'b1);
    issue(24'h00A102, 1'b1);
    drain();

    // R3 R9: zero address setup and zero strobe act as one
    setCfg(0, 0, 0, 0, 0, 0);
    issue(24'h005555, 1'b0);
    issue(24'h005556, 1'b1);
    drain();

    // R4 R6: 8-bit data page burst
    setCfg(1, 1, 2, 2, 1, 2);
    issue(24'hC3B200, 1'b0);
    issue(24'hC3B201, 1'b1);
    issue(24'hC3B202, 1'b1);
    issue(24'hC3B203, 1'b1);
    drain();

    // R4: zero address setup, no latch phase
    setCfg(1, 0, 0, 3, 2, 0);
    issue(24'h7E0010, 1'b0);
    issue(24'h7E0011, 1'b1);
    drain();

    // R5 R6 R8: separate address lines, then a miss while busy
    setCfg(2, 3, 0, 2, 1, 0);
    issue(24'h12F0F0, 1'b0);
    issue(24'h12F0F1, 1'b1);
    issue(24'h12F0F2, 1'b0);
    issue(24'h12F0F3, 1'b0);
    drain();

    // R10: configuration changed after start has no effect
    setCfg(1, 2, 1, 3, 2, 1);
    issue(24'h445566, 1'b0);
    setCfg(0, 9, 5, 9, 9, 3);
    issue(24'h445567, 1'b1);
    drain();

    finishRun();
  end

endmodule